// File: doc/BRIEF.md
# Serial Controller Control Port

This block is the processor-facing register port of a programmable serial controller. A processor reaches it over an 8-bit bus with an active-low chip select, active-low read and write strobes and a control/data select line. With the select low, a write hands a byte to the transmitter and a read returns the received byte. With the select high, a write goes to the control sequencer and a read returns the status byte.

The control sequencer is ordered. After an external reset, or after a command that requests an internal reset, the first control write is stored as the mode byte. If that mode selects synchronous operation, one or two sync-character writes follow before the port takes commands. Every later control write is a command. Some command bits are held as levels that drive the datapaths. Others give one-cycle pulses.

The status byte is put together from the datapath flags and the modem-ready input. The serial datapaths that use the mode byte, the sync characters and the command levels are outside this block.

Top module: `sio_ctrl_port`

## Requirements
- R1: While rst_n is low at a rising clock edge, all command levels, pulses, mode_word, sync_char1, sync_char2 and tx_byte clear to zero, and the next control write is taken as the mode byte.
- R2: The first control write after any reset is stored in mode_word. Bits [1:0] of that byte set the rate: 00 selects synchronous operation (sync_mode high), and 01, 10 and 11 select asynchronous operation with clock factors of x1, x16 and x64.
- R3: In synchronous mode, the control writes that follow the mode byte load sync_char1, and then sync_char2 unless mode bit 7 is 1, which asks for a single sync character. These writes leave every command output unchanged. The control write after them is the first command.
- R4: A command write sets the held levels from its bits: bit 0 tx_en, bit 1 dtr, bit 2 rx_en, bit 3 brk, bit 5 rts. A later command replaces all of these levels.
- R5: Command bit 4 raises err_rst and command bit 7 raises hunt, each for exactly one clock cycle. Neither bit is held.
- R6: Command bit 6 raises int_rst for one cycle and clears all command levels in that same cycle. The next control write is then taken as a mode byte, and the other bits of that command have no effect.
- R7: A data write (cd low) while the port is accepting commands raises tx_load for one cycle, with the written byte on tx_byte. A data write at any earlier point in the sequence is ignored.
- R8: While a status read is active (cs_n, rd_n low, cd high), dout carries bit 0 TX ready, bit 1 RX ready, bit 2 TX empty, bit 3 parity error, bit 4 overrun error, bit 5 framing error, bit 6 sync/break detect and bit 7 the inverse of dsr_n.
- R9: While a data read is active (cd low), dout carries rx_byte, and rx_take pulses for one cycle for each read access. With no read active, dout is zero.
- R10: No access happens while cs_n is high. A strobe held low over several cycles counts as one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | High: control/status, low: data |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| rx_byte | input | 8 | Received byte from the receiver |
| txrdy_f | input | 1 | Transmitter ready flag |
| rxrdy_f | input | 1 | Receiver ready flag |
| txemp_f | input | 1 | Transmitter empty flag |
| par_f | input | 1 | Parity error flag |
| ovr_f | input | 1 | Overrun error flag |
| frm_f | input | 1 | Framing error flag |
| synbrk_f | input | 1 | Sync or break detect flag |
| dsr_n | input | 1 | Data-set-ready, active low |
| mode_word | output | 8 | Stored mode byte |
| sync_mode | output | 1 | Synchronous operation selected |
| sync_char1 | output | 8 | First sync character |
| sync_char2 | output | 8 | Second sync character |
| tx_en | output | 1 | Transmitter enable level |
| rx_en | output | 1 | Receiver enable level |
| dtr | output | 1 | Data-terminal-ready level |
| rts | output | 1 | Request-to-send level |
| brk | output | 1 | Send-break level |
| err_rst | output | 1 | One-cycle error-flag clear |
| int_rst | output | 1 | One-cycle internal reset |
| hunt | output | 1 | One-cycle enter-hunt request |
| tx_load | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Byte for the transmitter |
| rx_take | output | 1 | One-cycle received-byte consumed |

## Verification
The sequencer is run through three control-write orderings: asynchronous mode followed by commands, synchronous mode with two sync characters, and synchronous mode with one. Comparing these tells a correct sync-count decode apart from an off-by-one that would take a command as a sync character. Data writes placed before and after the mode byte show whether the transmit strobe is properly held off until the command phase. Two status patterns with complementary bit sets, together with reads, writes with the chip deselected and writes with a strobe held low, separate bit mapping errors from access-qualification and edge-detection faults.

// File: rtl/sio_pkg.sv
// Shared definitions for the serial controller control port: sequencer
// states, command bit positions, status bit positions and mode fields.
package sio_pkg;
    typedef enum logic [1:0] {
        ST_MODE  = 2'd0,
        ST_SYNC1 = 2'd1,
        ST_SYNC2 = 2'd2,
        ST_CMD   = 2'd3
    } seq_state_t;

    localparam int BUS_W   = 8;

    // command byte bit positions
    localparam int CB_TXEN = 0;
    localparam int CB_DTR  = 1;
    localparam int CB_RXEN = 2;
    localparam int CB_BRK  = 3;
    localparam int CB_ERST = 4;
    localparam int CB_RTS  = 5;
    localparam int CB_IRST = 6;
    localparam int CB_HUNT = 7;

    // status byte bit positions
    localparam int SB_TXRDY = 0;
    localparam int SB_RXRDY = 1;
    localparam int SB_TXEMP = 2;
    localparam int SB_PAR   = 3;
    localparam int SB_OVR   = 4;
    localparam int SB_FRM   = 5;
    localparam int SB_SYNBK = 6;
    localparam int SB_DSR   = 7;

    // mode byte fields
    localparam int          MB_ONE_SYNC = 7;
    localparam logic [1:0]  FAC_SYNC    = 2'b00;
endpackage

// File: rtl/sio_bus_decode.sv
// Bus access decoder. It qualifies the strobes with the chip select, keeps
// only the first cycle of each strobe so that a held strobe counts once, and
// splits accesses into control and data. Assumes strobes are synchronous to clk.
module sio_bus_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic cd,
    output logic wr_ctl,
    output logic wr_dat,
    output logic rd_stat,
    output logic rd_data,
    output logic rx_take
);
    logic wr_lvl, rd_lvl;
    logic wr_d, rd_d;

    assign wr_lvl  = !cs_n && !wr_n;
    assign rd_lvl  = !cs_n && !rd_n;
    assign wr_ctl  = wr_lvl && !wr_d && cd;
    assign wr_dat  = wr_lvl && !wr_d && !cd;
    assign rd_stat = rd_lvl && cd;
    assign rd_data = rd_lvl && !cd;

    // Remember the strobe levels of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_d <= 1'b0;
            rd_d <= 1'b0;
        end else begin
            wr_d <= wr_lvl;
            rd_d <= rd_lvl;
        end
    end

    // Give a one-cycle pulse when a data read access begins.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_take <= 1'b0;
        else        rx_take <= rd_lvl && !rd_d && !cd;
    end
endmodule

// File: rtl/sio_ctrl_seq.sv
// Control sequencer. It steps through mode, optional sync characters and
// command phases, holds the command levels and issues one-cycle command
// pulses and transmit-byte strobes. Assumes write requests last one cycle.
module sio_ctrl_seq
    import sio_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctl,
    input  logic         wr_dat,
    input  logic [W-1:0] din,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] sync1_q,
    output logic [W-1:0] sync2_q,
    output logic [W-1:0] lvl_q,
    output logic         err_rst,
    output logic         int_rst,
    output logic         hunt,
    output logic         tx_load,
    output logic [W-1:0] tx_byte
);
    localparam logic [W-1:0] LVL_MASK = W'((1 << CB_TXEN) | (1 << CB_DTR) |
                                           (1 << CB_RXEN) | (1 << CB_BRK) |
                                           (1 << CB_RTS));

    seq_state_t st;

    // Advance the sequence and store the mode, sync and command bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_MODE;
            mode_q  <= '0;
            sync1_q <= '0;
            sync2_q <= '0;
            lvl_q   <= '0;
            err_rst <= 1'b0;
            int_rst <= 1'b0;
            hunt    <= 1'b0;
        end else begin
            err_rst <= 1'b0;
            int_rst <= 1'b0;
            hunt    <= 1'b0;
            if (wr_ctl) begin
                unique case (st)
                    ST_MODE: begin
                        mode_q <= din;
                        st     <= (din[1:0] == FAC_SYNC) ? ST_SYNC1 : ST_CMD;
                    end
                    ST_SYNC1: begin
                        sync1_q <= din;
                        st      <= mode_q[MB_ONE_SYNC] ? ST_CMD : ST_SYNC2;
                    end
                    ST_SYNC2: begin
                        sync2_q <= din;
                        st      <= ST_CMD;
                    end
                    ST_CMD: begin
                        if (din[CB_IRST]) begin
                            lvl_q   <= '0;
                            int_rst <= 1'b1;
                            st      <= ST_MODE;
                        end else begin
                            lvl_q   <= din & LVL_MASK;
                            err_rst <= din[CB_ERST];
                            hunt    <= din[CB_HUNT];
                        end
                    end
                    default: st <= ST_MODE;
                endcase
            end
        end
    end

    // Pass transmit bytes to the datapath only once commands are accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_load <= 1'b0;
            tx_byte <= '0;
        end else begin
            tx_load <= wr_dat && (st == ST_CMD);
            if (wr_dat && (st == ST_CMD)) tx_byte <= din;
        end
    end
endmodule

// File: rtl/sio_status_mux.sv
// Read path. It builds the status byte from the datapath flags and the
// modem input and picks status, received byte or zero for the bus.
// Purely combinational.
module sio_status_mux
    import sio_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         rd_stat,
    input  logic         rd_data,
    input  logic [W-1:0] rx_byte,
    input  logic         txrdy_f,
    input  logic         rxrdy_f,
    input  logic         txemp_f,
    input  logic         par_f,
    input  logic         ovr_f,
    input  logic         frm_f,
    input  logic         synbrk_f,
    input  logic         dsr_n,
    output logic [W-1:0] dout
);
    logic [W-1:0] stat;

    // Place each flag at its status bit position.
    always_comb begin
        stat           = '0;
        stat[SB_TXRDY] = txrdy_f;
        stat[SB_RXRDY] = rxrdy_f;
        stat[SB_TXEMP] = txemp_f;
        stat[SB_PAR]   = par_f;
        stat[SB_OVR]   = ovr_f;
        stat[SB_FRM]   = frm_f;
        stat[SB_SYNBK] = synbrk_f;
        stat[SB_DSR]   = !dsr_n;
    end

    // Select what goes onto the read bus.
    always_comb begin
        if (rd_stat)      dout = stat;
        else if (rd_data) dout = rx_byte;
        else              dout = '0;
    end
endmodule

// File: rtl/sio_ctrl_port.sv
// Top level of the control port. It connects the bus decoder, the control
// sequencer and the read multiplexer, and breaks the command levels out to
// named outputs. Assumes every bus input is synchronous to clk.
module sio_ctrl_port
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       cd,
    input  logic [7:0] din,
    output logic [7:0] dout,
    input  logic [7:0] rx_byte,
    input  logic       txrdy_f,
    input  logic       rxrdy_f,
    input  logic       txemp_f,
    input  logic       par_f,
    input  logic       ovr_f,
    input  logic       frm_f,
    input  logic       synbrk_f,
    input  logic       dsr_n,
    output logic [7:0] mode_word,
    output logic       sync_mode,
    output logic [7:0] sync_char1,
    output logic [7:0] sync_char2,
    output logic       tx_en,
    output logic       rx_en,
    output logic       dtr,
    output logic       rts,
    output logic       brk,
    output logic       err_rst,
    output logic       int_rst,
    output logic       hunt,
    output logic       tx_load,
    output logic [7:0] tx_byte,
    output logic       rx_take
);
    logic       wr_ctl, wr_dat, rd_stat, rd_data;
    logic [7:0] lvl;

    sio_bus_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .cd(cd), .wr_ctl(wr_ctl), .wr_dat(wr_dat), .rd_stat(rd_stat),
        .rd_data(rd_data), .rx_take(rx_take)
    );

    sio_ctrl_seq #(.W(BUS_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_dat(wr_dat),
        .din(din), .mode_q(mode_word), .sync1_q(sync_char1),
        .sync2_q(sync_char2), .lvl_q(lvl), .err_rst(err_rst),
        .int_rst(int_rst), .hunt(hunt), .tx_load(tx_load), .tx_byte(tx_byte)
    );

    sio_status_mux #(.W(BUS_W)) u_mux (
        .rd_stat(rd_stat), .rd_data(rd_data), .rx_byte(rx_byte),
        .txrdy_f(txrdy_f), .rxrdy_f(rxrdy_f), .txemp_f(txemp_f),
        .par_f(par_f), .ovr_f(ovr_f), .frm_f(frm_f), .synbrk_f(synbrk_f),
        .dsr_n(dsr_n), .dout(dout)
    );

    assign sync_mode = (mode_word[1:0] == FAC_SYNC);
    assign tx_en     = lvl[CB_TXEN];
    assign rx_en     = lvl[CB_RXEN];
    assign dtr       = lvl[CB_DTR];
    assign rts       = lvl[CB_RTS];
    assign brk       = lvl[CB_BRK];
endmodule

// File: rtl/sio_ctrl_port_chk.sv
// Assertion checker for the control port, attached by bind.
module sio_ctrl_port_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic tx_en,
    input logic rx_en,
    input logic rts,
    input logic dtr,
    input logic brk,
    input logic err_rst,
    input logic int_rst,
    input logic hunt,
    input logic tx_load,
    input logic rx_take
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !tx_en && !rx_en && !rts && !dtr && !brk && !tx_load);

    // R5
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_rst |=> !err_rst);

    // R5
    hunt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hunt |=> !hunt);

    // R6
    irst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |-> !tx_en && !rx_en && !rts && !dtr && !brk && !err_rst && !hunt);

    // R7
    txload_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);

    // R10
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !tx_load && !err_rst && !int_rst && !hunt && !rx_take);
endmodule

bind sio_ctrl_port sio_ctrl_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .tx_en(tx_en), .rx_en(rx_en),
    .rts(rts), .dtr(dtr), .brk(brk), .err_rst(err_rst), .int_rst(int_rst),
    .hunt(hunt), .tx_load(tx_load), .rx_take(rx_take)
);

// File: tb/tb_sio_ctrl_port.sv
module tb_sio_ctrl_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
    logic [7:0] din = '0, rx_byte = '0;
    logic       txrdy_f = 0, rxrdy_f = 0, txemp_f = 0, par_f = 0;
    logic       ovr_f = 0, frm_f = 0, synbrk_f = 0, dsr_n = 1;
    logic [7:0] dout, mode_word, sync_char1, sync_char2, tx_byte;
    logic       sync_mode, tx_en, rx_en, dtr, rts, brk;
    logic       err_rst, int_rst, hunt, tx_load, rx_take;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    sio_ctrl_port dut (.*);

    always #5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_phase;          // 0 mode, 1 first sync, 2 second sync, 3 commands
    int m_mode, m_s1, m_s2, m_cmd, m_txb;
    int m_erst, m_irst, m_hunt, m_txl, m_rxt;
    bit m_pw, m_pr;

    always @(posedge clk) begin
        bit wl, rl, wfirst;
        cyc++;
        wl = !cs_n && !wr_n;
        rl = !cs_n && !rd_n;
        wfirst = wl && !m_pw;
        if (!rst_n) begin
            m_phase = 0; m_mode = 0; m_s1 = 0; m_s2 = 0; m_cmd = 0; m_txb = 0;
            m_erst = 0; m_irst = 0; m_hunt = 0; m_txl = 0; m_rxt = 0;
            m_pw = 0; m_pr = 0;
        end else begin
            m_erst = 0; m_irst = 0; m_hunt = 0;
            m_txl = (wfirst && !cd && m_phase == 3) ? 1 : 0;
            if (m_txl == 1) m_txb = int'(din);
            m_rxt = (rl && !m_pr && !cd) ? 1 : 0;
            if (wfirst && cd) begin
                if (m_phase == 0) begin
                    m_mode = int'(din);
                    m_phase = (din % 4 == 0) ? 1 : 3;
                end else if (m_phase == 1) begin
                    m_s1 = int'(din);
                    m_phase = (m_mode >= 128) ? 3 : 2;
                end else if (m_phase == 2) begin
                    m_s2 = int'(din);
                    m_phase = 3;
                end else if ((din / 64) % 2 == 1) begin
                    m_cmd = 0; m_irst = 1; m_phase = 0;
                end else begin
                    m_cmd = int'(din);
                    m_erst = (din / 16) % 2;
                    m_hunt = din / 128;
                end
            end
            m_pw = wl;
            m_pr = rl;
        end
    end

    function automatic int exp_dout();
        int s;
        if (cs_n || rd_n) return 0;
        if (!cd) return int'(rx_byte);
        s = txrdy_f + 2*rxrdy_f + 4*txemp_f + 8*par_f + 16*ovr_f + 32*frm_f
            + 64*synbrk_f + 128*(dsr_n ? 0 : 1);
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cmpv(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // Compare every output against the model once per cycle.
    always begin
        @(negedge clk);
        #2;
        if (cyc > 1) begin
            cmpv("R2 mode_word", int'(mode_word), m_mode);
            cmpv("R2 sync_mode", int'(sync_mode), (m_mode % 4 == 0) ? 1 : 0);
            cmpv("R3 sync_char1", int'(sync_char1), m_s1);
            cmpv("R3 sync_char2", int'(sync_char2), m_s2);
            cmpv("R4 tx_en", int'(tx_en), m_cmd % 2);
            cmpv("R4 dtr", int'(dtr), (m_cmd / 2) % 2);
            cmpv("R4 rx_en", int'(rx_en), (m_cmd / 4) % 2);
            cmpv("R4 brk", int'(brk), (m_cmd / 8) % 2);
            cmpv("R4 rts", int'(rts), (m_cmd / 32) % 2);
            cmpv("R5 err_rst", int'(err_rst), m_erst);
            cmpv("R5 hunt", int'(hunt), m_hunt);
            cmpv("R6 int_rst", int'(int_rst), m_irst);
            cmpv("R7 tx_load", int'(tx_load), m_txl);
            cmpv("R7 tx_byte", int'(tx_byte), m_txb);
            cmpv("R9 rx_take", int'(rx_take), m_rxt);
            cmpv("R8/R9 dout", int'(dout), exp_dout());
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_wr(input bit c, input logic [7:0] b, input bit sel);
        @(negedge clk);
        cs_n = !sel; wr_n = 1'b0; cd = c; din = b;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cmpv("R1 tx_en after reset", int'(tx_en), 0);
        cmpv("R1 mode_word after reset", int'(mode_word), 0);

        // R2: asynchronous mode x16, then commands
        bus_wr(1, 8'h4E, 1);
        cmpv("R2 mode stored", int'(mode_word), 8'h4E);
        cmpv("R2 async selected", int'(sync_mode), 0);
        bus_wr(1, 8'h27, 1);
        cmpv("R4 tx_en", int'(tx_en), 1);
        cmpv("R4 rts", int'(rts), 1);
        cmpv("R4 brk", int'(brk), 0);
        bus_wr(1, 8'h08, 1);
        cmpv("R4 brk set", int'(brk), 1);
        cmpv("R4 tx_en replaced", int'(tx_en), 0);

        // R5: error reset and hunt pulses
        bus_wr(1, 8'h37, 1);
        cmpv("R5 err_rst pulse", int'(err_rst), 1);
        idle(1);
        cmpv("R5 err_rst not held", int'(err_rst), 0);
        cmpv("R5 tx_en kept", int'(tx_en), 1);
        bus_wr(1, 8'hA7, 1);
        cmpv("R5 hunt pulse", int'(hunt), 1);
        idle(1);
        cmpv("R5 hunt not held", int'(hunt), 0);

        // R7: data write in command phase
        bus_wr(0, 8'h5A, 1);
        cmpv("R7 tx_load", int'(tx_load), 1);
        cmpv("R7 tx_byte", int'(tx_byte), 8'h5A);

        // R8: status, two complementary patterns
        @(negedge clk);
        txrdy_f = 1; par_f = 1; synbrk_f = 1; dsr_n = 0;
        cs_n = 0; rd_n = 0; cd = 1;
        #1 cmpv("R8 status pattern A", int'(dout), 8'hC9);
        @(negedge clk);
        txrdy_f = 0; par_f = 0; synbrk_f = 0; dsr_n = 1;
        rxrdy_f = 1; txemp_f = 1; ovr_f = 1; frm_f = 1;
        #1 cmpv("R8 status pattern B", int'(dout), 8'h36);
        @(negedge clk);
        cs_n = 1; rd_n = 1;
        #1 cmpv("R9 dout idle", int'(dout), 0);

        // R9: data read
        @(negedge clk);
        rx_byte = 8'hA5; cs_n = 0; rd_n = 0; cd = 0;
        #1 cmpv("R9 rx byte", int'(dout), 8'hA5);
        @(negedge clk);
        cs_n = 1; rd_n = 1;
        cmpv("R9 rx_take", int'(rx_take), 1);

        // R10: deselected write, held strobe
        bus_wr(1, 8'h00, 0);
        cmpv("R10 deselected ignored", int'(tx_en), 1);
        @(negedge clk);
        cs_n = 0; wr_n = 0; cd = 1; din = 8'h17;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cnt += int'(err_rst);
        end
        cs_n = 1; wr_n = 1;
        cmpv("R10 held strobe once", cnt, 1);

        // R6: internal reset
        bus_wr(1, 8'h67, 1);
        cmpv("R6 int_rst pulse", int'(int_rst), 1);
        cmpv("R6 levels cleared", int'(rts), 0);
        cmpv("R6 other bits unused", int'(dtr), 0);

        // R3: synchronous mode, two sync characters
        bus_wr(0, 8'h11, 1);
        cmpv("R7 data before mode ignored", int'(tx_load), 0);
        bus_wr(1, 8'h00, 1);
        cmpv("R2 sync mode", int'(sync_mode), 1);
        bus_wr(0, 8'h22, 1);
        cmpv("R7 data during sync ignored", int'(tx_load), 0);
        bus_wr(1, 8'h16, 1);
        cmpv("R3 sync1", int'(sync_char1), 8'h16);
        bus_wr(1, 8'h27, 1);
        cmpv("R3 sync2", int'(sync_char2), 8'h27);
        cmpv("R3 sync write not command", int'(tx_en), 0);
        bus_wr(1, 8'h01, 1);
        cmpv("R3 command after syncs", int'(tx_en), 1);

        // R3: single sync character
        bus_wr(1, 8'h40, 1);
        bus_wr(1, 8'h80, 1);
        bus_wr(1, 8'hAB, 1);
        cmpv("R3 single sync1", int'(sync_char1), 8'hAB);
        bus_wr(1, 8'h04, 1);
        cmpv("R3 single sync then command", int'(rx_en), 1);
        cmpv("R3 sync2 untouched", int'(sync_char2), 8'h27);

        // R1: external reset mid-operation
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        cmpv("R1 levels cleared", int'(rx_en), 0);
        bus_wr(1, 8'h05, 1);
        cmpv("R1 next write is mode", int'(mode_word), 8'h05);
        cmpv("R1 mode write not command", int'(tx_en), 0);

        idle(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule